// File: doc/BRIEF.md
# Transcoding FEC Parity Encoder

This block sits on the transmit side of a 64B/66B link that adds a forward error correcting code. It takes one 66-bit coded block per accepted cycle and shrinks it to 65 bits. The two sync bits are dropped, and a single transcode bit, formed from the second sync bit and payload bit D8 for DC balance, is placed in front of the 64 payload bits. Thirty-two such words form a 2080-bit message. Over that message the block accumulates 32 check bits of a shortened (2112,2080) cyclic code, with 65 bits folded in per cycle.

The 32 data words leave through a registered output one cycle after each is accepted. When the last word of a message has been taken, the input stalls for one cycle and the 32 parity bits appear with their own strobe. A bypass input lets raw 66-bit blocks through untouched and adds no parity. It only counts when no message is partly collected.

Top module: `tfe_encoder`

## Requirements
- R1: Input fields are in_blk[0]=S0, in_blk[1]=S1 and in_blk[65:2]=D0..D63, so D8 is in_blk[10]. For a coded word, out_data[0] equals S1 XOR D8.
- R2: A coded word accepted in cycle t shows in cycle t+1 with out_valid=1, out_bypassed=0, out_data[64:1]=in_blk[65:2] and out_data[65]=0.
- R3: After the 32nd coded word of a message is accepted, in_ready is low for exactly one cycle and nothing is accepted then. In the next cycle out_par_valid is high for one cycle and out_valid is low.
- R4: Parity is the remainder of M(x)·x^32 divided by g(x)=x^32+x^23+x^21+x^11+x^2+1. The 2080 message bits are taken in transmission order (words in arrival order, each word from out_data[0] up to out_data[64]), and the first bit is the highest power. out_par[i] holds the remainder coefficient of x^(31-i), so out_par[0] is sent first.
- R5: The 2080 message bits followed by out_par[0..31] leave a zero remainder when divided by g(x).
- R6: The parity state restarts at each message. A message's parity does not depend on any earlier message.
- R7: Cycles with in_valid low do not advance the word count or the parity. During such a cycle out_valid is low in the following cycle.
- R8: bypass is looked at only when no coded word of the current message has been accepted. While a message is partly collected, bypass is ignored and words stay coded.
- R9: A block accepted with bypass high at a message boundary appears the next cycle as out_data=in_blk with out_bypassed=1. It neither starts a message nor causes a parity cycle.
- R10: While reset is applied and right after it, in_ready=1, out_valid=0 and out_par_valid=0.
- R11: out_valid and out_par_valid are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input block offered |
| in_ready | output | 1 | Block can be taken this cycle |
| in_blk | input | 66 | 64B/66B block, sync header in bits 1:0 |
| bypass | input | 1 | Pass blocks raw; honoured only at a message boundary |
| out_valid | output | 1 | out_data holds a new word |
| out_data | output | 66 | Coded word in bits 64:0 (bit 65 zero), or raw block |
| out_bypassed | output | 1 | out_data holds a raw block |
| out_par_valid | output | 1 | out_par holds the finished parity of a message |
| out_par | output | 32 | Parity bits, bit 0 sent first |

## Verification
The bench builds the block with its default parameters: 32 words per message and the 32-bit generator. This puts the full 2080-bit message within reach, so every parity is checked against a bit-serial divider and by dividing the whole codeword again. Defaults also make the end-of-message stall, the input held through the stall, and the boundary rule for bypass occur at their real word positions. Idle gaps inside a message and bypass raised mid-message are driven in their own tasks.

// File: rtl/tfe_pkg.sv
package tfe_pkg;
  localparam int SYNC_W = 2;
  localparam int PAY_W  = 64;
  localparam int BLK_W  = SYNC_W + PAY_W;
  localparam int XW     = PAY_W + 1;
  localparam int PAR_W  = 32;
  localparam int TAP    = 8;

  typedef logic [BLK_W-1:0] blk_t;
  typedef logic [XW-1:0]    xword_t;
  typedef logic [PAR_W-1:0] par_t;

  // DC-balancing bit: second sync bit xor payload bit TAP
  function automatic logic xcode_bit(blk_t b);
    return b[1] ^ b[SYNC_W + TAP];
  endfunction

  function automatic xword_t transcode(blk_t b);
    return {b[BLK_W-1:SYNC_W], xcode_bit(b)};
  endfunction

  // Fold one word into the remainder, bit 0 first, first bit highest power
  function automatic par_t par_step(par_t r, xword_t w, par_t poly);
    par_t acc;
    logic fb;
    acc = r;
    for (int i = 0; i < XW; i++) begin
      fb  = w[i] ^ acc[PAR_W-1];
      acc = {acc[PAR_W-2:0], 1'b0} ^ (fb ? poly : '0);
    end
    return acc;
  endfunction

  // Put the highest coefficient at bit 0 (sent first)
  function automatic par_t par_order(par_t r);
    par_t o;
    for (int i = 0; i < PAR_W; i++) o[i] = r[PAR_W-1-i];
    return o;
  endfunction
endpackage

// File: rtl/tfe_xcode_unit.sv
module tfe_xcode_unit
  import tfe_pkg::*;
(
  input  blk_t   blk,
  output xword_t xword,
  output logic   xbit
);
  assign xbit = xcode_bit(blk);

  for (genvar k = 0; k < PAY_W; k++) begin : g_pay
    assign xword[k+1] = blk[SYNC_W + k];
  end
  assign xword[0] = xbit;
endmodule

// File: rtl/tfe_msg_seq.sv
module tfe_msg_seq #(
  parameter int WORDS_PER_MSG = 32,
  localparam int CW = (WORDS_PER_MSG > 1) ? $clog2(WORDS_PER_MSG) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          bypass,
  output logic          in_ready,
  output logic          accept,
  output logic          take_byp,
  output logic          coded_acc,
  output logic          msg_first,
  output logic          msg_last,
  output logic          par_slot,
  output logic [CW-1:0] word_cnt
);
  localparam logic [CW-1:0] LAST = CW'(WORDS_PER_MSG - 1);

  logic          pend_q;
  logic [CW-1:0] cnt_q;
  logic          at_boundary;

  assign at_boundary = (cnt_q == '0);
  assign in_ready    = !pend_q;
  assign accept      = in_valid && in_ready;
  assign take_byp    = accept && bypass && at_boundary;
  assign coded_acc   = accept && !take_byp;
  assign msg_first   = coded_acc && at_boundary;
  assign msg_last    = coded_acc && (cnt_q == LAST);
  assign par_slot    = pend_q;
  assign word_cnt    = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      pend_q <= msg_last;
      if (msg_last)       cnt_q <= '0;
      else if (coded_acc) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/tfe_par_acc.sv
module tfe_par_acc
  import tfe_pkg::*;
#(
  parameter par_t GEN_POLY = 32'h00A0_0805
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   step,
  input  logic   first,
  input  xword_t xword,
  output par_t   rem
);
  par_t rem_q;
  par_t base;

  assign base = first ? '0 : rem_q;
  assign rem  = rem_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    rem_q <= '0;
    else if (step) rem_q <= par_step(base, xword, GEN_POLY);
  end
endmodule

// File: rtl/tfe_encoder.sv
module tfe_encoder
  import tfe_pkg::*;
#(
  parameter int   WORDS_PER_MSG = 32,
  parameter logic [31:0] GEN_POLY = 32'h00A0_0805,
  localparam int  CW = (WORDS_PER_MSG > 1) ? $clog2(WORDS_PER_MSG) : 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [65:0] in_blk,
  input  logic        bypass,
  output logic        out_valid,
  output logic [65:0] out_data,
  output logic        out_bypassed,
  output logic        out_par_valid,
  output logic [31:0] out_par
);
  xword_t        xword;
  logic          xbit;
  logic          accept, take_byp, coded_acc, msg_first, msg_last, par_slot;
  logic [CW-1:0] word_cnt;
  par_t          rem;

  tfe_xcode_unit u_xcode (
    .blk   (in_blk),
    .xword (xword),
    .xbit  (xbit)
  );

  tfe_msg_seq #(.WORDS_PER_MSG(WORDS_PER_MSG)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .bypass    (bypass),
    .in_ready  (in_ready),
    .accept    (accept),
    .take_byp  (take_byp),
    .coded_acc (coded_acc),
    .msg_first (msg_first),
    .msg_last  (msg_last),
    .par_slot  (par_slot),
    .word_cnt  (word_cnt)
  );

  tfe_par_acc #(.GEN_POLY(GEN_POLY)) u_par (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (coded_acc),
    .first (msg_first),
    .xword (xword),
    .rem   (rem)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_data      <= '0;
      out_bypassed  <= 1'b0;
      out_par_valid <= 1'b0;
      out_par       <= '0;
    end else begin
      out_valid     <= accept;
      out_par_valid <= par_slot;
      if (accept) begin
        out_data     <= take_byp ? in_blk : {1'b0, xword};
        out_bypassed <= take_byp;
      end
      if (par_slot) out_par <= par_order(rem);
    end
  end
endmodule

// File: rtl/tfe_encoder_chk.sv
module tfe_encoder_chk #(
  parameter int WORDS_PER_MSG = 32,
  localparam int CW = (WORDS_PER_MSG > 1) ? $clog2(WORDS_PER_MSG) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [65:0]   in_blk,
  input logic          bypass,
  input logic          out_valid,
  input logic [65:0]   out_data,
  input logic          out_bypassed,
  input logic          out_par_valid,
  input logic          take_byp,
  input logic [CW-1:0] word_cnt
);
  AST_STALL_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> in_ready);  // R3
  AST_PAR_AFTER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> out_par_valid);  // R3
  AST_PAR_NEEDS_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_par_valid |-> $past(!in_ready));  // R3
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && out_par_valid));  // R11
  AST_XCODE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !take_byp) |=> (out_data[0] == ($past(in_blk[1]) ^ $past(in_blk[10]))));  // R1
  AST_MID_NO_BYP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && word_cnt != '0) |=> (out_valid && !out_bypassed));  // R8
  AST_BYP_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && bypass && word_cnt == '0) |=> (out_bypassed && out_data == $past(in_blk)));  // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(word_cnt) && !out_valid));  // R7
endmodule

bind tfe_encoder tfe_encoder_chk #(.WORDS_PER_MSG(WORDS_PER_MSG)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .in_ready      (in_ready),
  .in_blk        (in_blk),
  .bypass        (bypass),
  .out_valid     (out_valid),
  .out_data      (out_data),
  .out_bypassed  (out_bypassed),
  .out_par_valid (out_par_valid),
  .take_byp      (take_byp),
  .word_cnt      (word_cnt)
);

// File: tb/tb_tfe_encoder.sv
`timescale 1ns/1ps
module tb_tfe_encoder;
  localparam int NW = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [65:0] in_blk = '0;
  logic        bypass = 1'b0;
  logic        out_valid;
  logic [65:0] out_data;
  logic        out_bypassed;
  logic        out_par_valid;
  logic [31:0] out_par;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [65:0] msg [NW];

  always #5 clk = ~clk;

  tfe_encoder dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_blk(in_blk), .bypass(bypass), .out_valid(out_valid),
    .out_data(out_data), .out_bypassed(out_bypassed),
    .out_par_valid(out_par_valid), .out_par(out_par)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [65:0] act, input logic [65:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // Expected coded word, written field by field
  function automatic logic [65:0] exp_word(input logic [65:0] b);
    logic [65:0] x;
    x = '0;
    x[0] = b[1] ^ b[10];
    for (int k = 0; k < 64; k++) x[k+1] = b[k+2];
    return x;
  endfunction

  // One bit into a serial divider built from the exponent list of g(x)
  function automatic logic [31:0] ser_bit(input logic [31:0] r, input logic b);
    logic [31:0] n;
    logic fb;
    int taps [5] = '{0, 2, 11, 21, 23};
    fb = b ^ r[31];
    n = r << 1;
    if (fb) for (int t = 0; t < 5; t++) n[taps[t]] = ~n[taps[t]];
    return n;
  endfunction

  function automatic logic [31:0] ref_rem();
    logic [31:0] r;
    logic [65:0] x;
    r = '0;
    for (int w = 0; w < NW; w++) begin
      x = exp_word(msg[w]);
      for (int k = 0; k < 65; k++) r = ser_bit(r, x[k]);
    end
    return r;
  endfunction

  function automatic logic [31:0] ref_par();
    logic [31:0] r, p;
    r = ref_rem();
    for (int i = 0; i < 32; i++) p[i] = r[31-i];
    return p;
  endfunction

  function automatic logic [31:0] codeword_rem(input logic [31:0] par);
    logic [31:0] r;
    r = ref_rem();
    for (int i = 0; i < 32; i++) r = ser_bit(r, par[i]);
    return r;
  endfunction

  function automatic logic [65:0] rnd66();
    return {$urandom(), $urandom(), 2'($urandom())};
  endfunction

  task automatic fill(input int mode);
    for (int w = 0; w < NW; w++) begin
      case (mode)
        0: msg[w] = '0;
        1: msg[w] = '1;
        default: msg[w] = rnd66();
      endcase
    end
  endtask

  // Send one message; gaps inserts idle cycles, stray raises bypass mid-message,
  // hold keeps a raw probe block offered across the stall slot.
  task automatic run_msg(input bit gaps, input bit stray, input bit hold,
                         input logic [65:0] probe);
    logic [65:0] e;
    @(negedge clk);
    for (int i = 0; i < NW; i++) begin
      if (gaps && (i % 5 == 2)) begin
        in_valid = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R7", "out_valid after idle", 66'(out_valid), 66'(0));
        chk(in_ready == 1'b1, "R7", "ready in gap", 66'(in_ready), 66'(1));
      end
      in_valid = 1'b1;
      in_blk   = msg[i];
      bypass   = stray && (i > 0);
      @(negedge clk);
      e = exp_word(msg[i]);
      chk(out_valid && !out_bypassed, stray ? "R8" : "R2", "valid/coded flag",
          {64'd0, out_valid, out_bypassed}, 66'b10);
      chk(out_data[0] == e[0], "R1", "transcode bit", 66'(out_data[0]), 66'(e[0]));
      chk(out_data == e, "R2", "coded word", out_data, e);
      if (i == NW-1)
        chk(in_ready == 1'b0, "R3", "ready in stall slot", 66'(in_ready), 66'(0));
    end
    if (hold) begin
      in_blk = probe;
      bypass = 1'b1;
    end else begin
      in_valid = 1'b0;
      bypass   = 1'b0;
    end
    @(negedge clk);
    chk(out_par_valid && !out_valid, "R3", "parity strobe, data idle",
        {64'd0, out_par_valid, out_valid}, 66'b10);
    chk(in_ready == 1'b1, "R3", "ready back after stall", 66'(in_ready), 66'(1));
    chk(out_par == ref_par(), "R4 R6", "parity", 66'(out_par), 66'(ref_par()));
    chk(codeword_rem(out_par) == '0, "R5", "codeword remainder",
        66'(codeword_rem(out_par)), 66'(0));
    if (hold) begin
      @(negedge clk);
      chk(out_valid && out_bypassed && out_data == probe, "R3",
          "held block taken after stall, raw", out_data, probe);
      chk(out_par_valid == 1'b0, "R3", "parity strobe one cycle", 66'(out_par_valid), 66'(0));
      in_valid = 1'b0;
      bypass   = 1'b0;
    end
  endtask

  task automatic t_reset();
    chk(in_ready == 1'b1 && out_valid == 1'b0 && out_par_valid == 1'b0, "R10",
        "state in reset", {63'd0, in_ready, out_valid, out_par_valid}, 66'b100);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1 && out_valid == 1'b0 && out_par_valid == 1'b0, "R10",
        "state after reset", {63'd0, in_ready, out_valid, out_par_valid}, 66'b100);
  endtask

  task automatic t_bypass_run();
    logic [65:0] b;
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      b = rnd66();
      in_valid = 1'b1;
      in_blk   = b;
      bypass   = 1'b1;
      @(negedge clk);
      chk(out_valid && out_bypassed && out_data == b, "R9", "raw pass", out_data, b);
      chk(in_ready == 1'b1, "R9", "no stall on raw", 66'(in_ready), 66'(1));
    end
    in_valid = 1'b0;
    bypass   = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(out_par_valid == 1'b0, "R9", "no parity after raw", 66'(out_par_valid), 66'(0));
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(posedge clk);
    t_reset();
    fill(0); run_msg(1'b0, 1'b0, 1'b0, '0);          // zero message, zero parity
    fill(1); run_msg(1'b0, 1'b0, 1'b0, '0);
    fill(2); run_msg(1'b0, 1'b0, 1'b0, '0);
    fill(2); run_msg(1'b0, 1'b0, 1'b0, '0);          // R6: restart per message
    fill(2); run_msg(1'b1, 1'b0, 1'b0, '0);          // R7: idle gaps
    fill(2); run_msg(1'b0, 1'b1, 1'b0, '0);          // R8: bypass mid-message
    t_bypass_run();                                  // R9
    fill(2); run_msg(1'b0, 1'b0, 1'b0, '0);          // counter untouched by raw blocks
    fill(2); run_msg(1'b0, 1'b0, 1'b1, rnd66());     // R3: held across stall
    fill(2); run_msg(1'b1, 1'b1, 1'b0, '0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule